// File: doc/BRIEF.md
# Sticky Masked Interrupt Event Monitor

This block collects status levels and one-cycle event pulses from a clock-synthesis controller and turns them into sticky interrupt flags. Each status level is watched for changes. A low-to-high change sets one flag and a high-to-low change sets a different flag. Each event pulse sets one flag of its own. The flags are packed into five 8-bit monitor groups. Each group has its own per-bit mask register and its own write-one-to-clear register. A single control bit clears every flag at once.

All inputs are synchronous to `clk`. The level detector samples every level once per clock. It stays quiet on the first clock after reset, so a level that is already high then raises no false transition. An external controller reaches the registers through a plain address and write-data port. Reads are combinational from `addr`. The `irq` output is high whenever any flag is latched.

Top module: `irqmon_top`

## Requirements
- R1: An event that is not masked sets its flag on the rising clock edge at which the event is sampled, so a flag is readable one clock after the change. A pulse counts when it is high at that edge. A level counts when it differs from the value it had on the previous edge.
- R2: A mask bit of 1 blocks its event, and the flag stays 0. Writing a mask register leaves flags that are already latched unchanged.
- R3: A latched flag stays at 1, whatever its inputs do, until it is cleared or the block is reset. Reset clears all flags.
- R4: Writing to clear register 0x10+g (g = 0..4) clears the flags of group g whose write-data bits are 1. The other flags are left as they were.
- R5: Writing control register 0x18 with bit 0 set clears every flag in every group in that cycle.
- R6: If an unmasked event and a clear (per-bit or clear-all) hit the same flag in the same cycle, the flag ends set.
- R7: Each status level drives two flags. The rising-change flag is the lower bit of the pair and the falling-change flag is the upper bit.
- R8: Group 0 is read at 0x00. Its bits are: 0 calibration started (rise of `cal_busy`), 1 calibration ended (fall), 2/3 `out_lock` rise/fall, 4/5 `sys_lock` rise/fall, bits 7:6 read 0. Group 1 is read at 0x01. Its bits 4:0 follow `misc_evt[4:0]` and bits 7:5 read 0.
- R9: Group 2 is read at 0x02. Its bits are: 0/1 `phase_lock` rise/fall, 2/3 `freq_lock` rise/fall, 7:4 `loop_evt[3:0]`. Group 3 is read at 0x03. Its bits are: 0/1 `slew_lim` rise/fall, 2/3 `freq_clamp` rise/fall, 4 `hist_upd`, 7:5 read 0. Group 4 is read at 0x04. Bits 0/1/2 are `ref_fault[0]` rise, `ref_fault[0]` fall and `ref_valid[0]`. Bits 4/5/6 are the same for index 1. Bits 3 and 7 read 0.
- R10: The mask register of group g is at 0x08+g and can be read and written. Its reserved bits read 0. After reset every implemented bit reads 1, meaning masked: 0x3F, 0x1F, 0xFF, 0x1F, 0x77 for groups 0 to 4.
- R11: `irq` is 1 exactly when at least one flag is latched, and it stays 1 for as long as any flag is set.
- R12: Writes to the monitor addresses 0x00–0x04 have no effect. The clear and control registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe for `addr` and `wr_data` |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| cal_busy | input | 1 | Output-PLL calibration in progress |
| out_lock | input | 1 | Output PLL locked |
| sys_lock | input | 1 | System PLL locked |
| phase_lock | input | 1 | Loop controller phase locked |
| freq_lock | input | 1 | Loop controller frequency locked |
| loop_evt | input | 4 | Pulses: holdover, free-run, closed-loop, reference switching |
| slew_lim | input | 1 | Phase-slew limiter active |
| freq_clamp | input | 1 | Frequency limiter clamping |
| hist_upd | input | 1 | Tuning-history update pulse |
| ref_fault | input | 2 | Reference fault levels, one per input |
| ref_valid | input | 2 | Reference validated pulses, one per input |
| misc_evt | input | 5 | Pulses: storage done, storage fault, watchdog expiry, output sync, pin-load end |
| irq | output | 1 | Aggregate interrupt |

## Verification
The bench drives every source in turn and checks that it sets only its own bit. A swapped or shifted bit map would show up as a wrong monitor value. A design that ignores the masks would latch flags while the reset masks are still in force. One that lets a mask write clear flags would lose a latched bit after the write. The bench lands a clear and an event on the same bit in the same cycle, with a per-bit clear and again with clear-all, so a design that gives the clear priority reads back 0. A partial clear must leave the other bits set, and `irq` must fall only when the last flag goes.

// File: rtl/irqmon_pkg.sv
// Package: shared sizes, address map and implemented-bit masks of the
// interrupt event monitor.
package irqmon_pkg;
    localparam int GRP_N  = 5;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 5;
    localparam int LVL_N  = 9;

    localparam logic [ADDR_W-1:0] MON_BASE  = 5'h00;
    localparam logic [ADDR_W-1:0] MASK_BASE = 5'h08;
    localparam logic [ADDR_W-1:0] CLR_BASE  = 5'h10;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h18;

    // Implemented bits of each group; reserved bits are 0.
    function automatic logic [REG_W-1:0] grp_impl(input int g);
        case (g)
            0:       return 8'h3F;
            1:       return 8'h1F;
            2:       return 8'hFF;
            3:       return 8'h1F;
            4:       return 8'h77;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/irqmon_edge.sv
// irqmon_edge: registers a vector of status levels once per clock and
// produces one-cycle rise and fall strobes by comparing each level with its
// previous sample. Assumes levels are synchronous to clk. Strobes are held
// off on the first clock after reset so an already-high level is not seen
// as a transition.
module irqmon_edge #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;
    logic         armed_q;

    // Keep the previous sample and arm detection after the first clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= lvl_i;
            armed_q <= 1'b1;
        end
    end

    assign rise_o = armed_q ? (lvl_i & ~prev_q) : '0;
    assign fall_o = armed_q ? (~lvl_i & prev_q) : '0;

    AST_EDGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_o & ~(lvl_i & ~$past(lvl_i))) == '0) &&
        ((fall_o & ~(~lvl_i & $past(lvl_i))) == '0)); // R7
endmodule

// File: rtl/irqmon_group.sv
// irqmon_group: one monitor register of sticky flags. A flag sets on an
// unmasked event and clears only on a clear-vector bit or reset; a
// same-cycle event wins over a clear. Bits outside IMPL are held at 0.
module irqmon_group #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    // Latch unmasked events, drop cleared bits, event has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= ((flags_q & ~clr_i) | (evt_i & ~mask_i)) & IMPL;
        end
    end

    assign flags_o = flags_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~clr_i) != '0) |=>
        ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i))); // R3

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & mask_i & ~flags_q) != '0) |=>
        ((flags_q & $past(evt_i & mask_i & ~flags_q)) == '0)); // R2

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & ~mask_i & clr_i & IMPL) != '0) |=>
        ((flags_q & $past(evt_i & ~mask_i & clr_i & IMPL)) ==
         $past(evt_i & ~mask_i & clr_i & IMPL))); // R6
endmodule

// File: rtl/irqmon_regs.sv
// irqmon_regs: register decode. Holds the mask registers (reset to
// masked), turns writes to the clear addresses and the clear-all bit into
// clear vectors, and multiplexes read data. Monitor addresses are read-only;
// clear and control addresses read 0.
module irqmon_regs
    import irqmon_pkg::*;
#(
    parameter int G  = GRP_N,
    parameter int W  = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr_i,
    input  logic                  wr_en_i,
    input  logic [W-1:0]          wr_data_i,
    input  logic [G-1:0][W-1:0]   flags_i,
    output logic [G-1:0][W-1:0]   mask_o,
    output logic [G-1:0][W-1:0]   clr_o,
    output logic                  clr_all_o,
    output logic [W-1:0]          rd_data_o
);
    logic [G-1:0][W-1:0] mask_q;

    // Mask registers: reset to all implemented bits masked, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < G; g++) mask_q[g] <= grp_impl(g);
        end else begin
            for (int g = 0; g < G; g++) begin
                if (wr_en_i && addr_i == AW'(MASK_BASE) + AW'(g))
                    mask_q[g] <= wr_data_i & grp_impl(g);
            end
        end
    end

    assign mask_o    = mask_q;
    assign clr_all_o = wr_en_i && (addr_i == AW'(CTRL_ADDR)) && wr_data_i[0];

    // Clear vectors: per-group write-one-to-clear, overridden by clear-all.
    always_comb begin
        for (int g = 0; g < G; g++) begin
            clr_o[g] = (wr_en_i && addr_i == AW'(CLR_BASE) + AW'(g)) ? wr_data_i : '0;
            if (clr_all_o) clr_o[g] = '1;
        end
    end

    // Read mux: monitor and mask registers; everything else reads 0.
    always_comb begin
        rd_data_o = '0;
        for (int g = 0; g < G; g++) begin
            if (addr_i == AW'(MON_BASE) + AW'(g))  rd_data_o = flags_i[g];
            if (addr_i == AW'(MASK_BASE) + AW'(g)) rd_data_o = mask_q[g];
        end
    end
endmodule

// File: rtl/irqmon_top.sv
// irqmon_top: interrupt event monitor. Maps status levels (through the
// transition detector) and event pulses onto five sticky flag groups,
// connects them to the register decode and ORs all flags into irq.
// Assumes every input is synchronous to clk.
module irqmon_top
    import irqmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              cal_busy,
    input  logic              out_lock,
    input  logic              sys_lock,
    input  logic              phase_lock,
    input  logic              freq_lock,
    input  logic [3:0]        loop_evt,
    input  logic              slew_lim,
    input  logic              freq_clamp,
    input  logic              hist_upd,
    input  logic [1:0]        ref_fault,
    input  logic [1:0]        ref_valid,
    input  logic [4:0]        misc_evt,
    output logic              irq
);
    logic [LVL_N-1:0]             lvl, rise, fall;
    logic [GRP_N-1:0][REG_W-1:0]  evt, mask, clr, flags;
    logic                         clr_all;
    logic                         pend_any;

    assign lvl = {ref_fault[1], ref_fault[0], freq_clamp, slew_lim,
                  freq_lock, phase_lock, sys_lock, out_lock, cal_busy};

    irqmon_edge #(.N(LVL_N)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    // Event vectors per group: rise on the lower bit of each pair.
    assign evt[0] = {2'b00, fall[2], rise[2], fall[1], rise[1], fall[0], rise[0]};
    assign evt[1] = {3'b000, misc_evt};
    assign evt[2] = {loop_evt, fall[4], rise[4], fall[3], rise[3]};
    assign evt[3] = {3'b000, hist_upd, fall[6], rise[6], fall[5], rise[5]};
    assign evt[4] = {1'b0, ref_valid[1], fall[8], rise[8],
                     1'b0, ref_valid[0], fall[7], rise[7]};

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        irqmon_group #(.W(REG_W), .IMPL(grp_impl(g))) i_group (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt[g]),
            .mask_i  (mask[g]),
            .clr_i   (clr[g]),
            .flags_o (flags[g])
        );
    end

    irqmon_regs #(.G(GRP_N), .W(REG_W), .AW(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .flags_i   (flags),
        .mask_o    (mask),
        .clr_o     (clr),
        .clr_all_o (clr_all),
        .rd_data_o (rd_data)
    );

    assign irq      = |flags;
    assign pend_any = |(evt & ~mask);

    AST_CLEAR_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !pend_any) |=> !irq); // R5
endmodule

// File: tb/test_irqmon_top.sv
`timescale 1ns/1ps
module test_irqmon_top;
    import irqmon_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0, rd_data;
    logic cal_busy = 0, out_lock = 0, sys_lock = 0, phase_lock = 0, freq_lock = 0;
    logic [3:0] loop_evt = '0;
    logic slew_lim = 0, freq_clamp = 0, hist_upd = 0;
    logic [1:0] ref_fault = '0, ref_valid = '0;
    logic [4:0] misc_evt = '0;
    logic irq;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    irqmon_top i_irqmon_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cal_busy(cal_busy), .out_lock(out_lock),
        .sys_lock(sys_lock), .phase_lock(phase_lock), .freq_lock(freq_lock),
        .loop_evt(loop_evt), .slew_lim(slew_lim), .freq_clamp(freq_clamp),
        .hist_upd(hist_upd), .ref_fault(ref_fault), .ref_valid(ref_valid),
        .misc_evt(misc_evt), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rdchk(input string req, input logic [4:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1 chk(req, rd_data, exp);
    endtask

    task automatic irqchk(input string req, input logic exp);
        #1 chk(req, {7'b0, irq}, {7'b0, exp});
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic pulse_misc(input logic [4:0] v);
        @(negedge clk); misc_evt = v;
        @(negedge clk); misc_evt = '0;
    endtask

    task automatic t_reset;
        for (int g = 0; g < GRP_N; g++) begin
            rdchk("R10 mask reset", MASK_BASE + 5'(g), grp_impl(g));
            rdchk("R3 flags zero after reset", MON_BASE + 5'(g), 8'h00);
        end
        irqchk("R11 irq low after reset", 1'b0);
    endtask

    task automatic t_masked;
        pulse_misc(5'h1F);
        @(negedge clk); out_lock = 1'b1; step();
        rdchk("R2 masked pulses", MON_BASE + 5'd1, 8'h00);
        rdchk("R2 masked level", MON_BASE + 5'd0, 8'h00);
        irqchk("R11 irq low when only masked events", 1'b0);
        @(negedge clk); out_lock = 1'b0; step();
    endtask

    task automatic t_unmask;
        wr(MASK_BASE + 5'd4, 8'hFF);
        rdchk("R10 reserved mask bits read 0", MASK_BASE + 5'd4, 8'h77);
        for (int g = 0; g < GRP_N; g++) wr(MASK_BASE + 5'(g), 8'h00);
        for (int g = 0; g < GRP_N; g++) rdchk("R10 mask write", MASK_BASE + 5'(g), 8'h00);
    endtask

    task automatic t_misc_map;
        for (int i = 0; i < 5; i++) begin
            pulse_misc(5'(1 << i));
            rdchk("R8 pulse group bit", MON_BASE + 5'd1, 8'(1 << i));
            irqchk("R11 irq high on flag", 1'b1);
            wr(CLR_BASE + 5'd1, 8'(1 << i));
            rdchk("R4 single bit clear", MON_BASE + 5'd1, 8'h00);
        end
    endtask

    task automatic t_pll_map;
        @(negedge clk); cal_busy = 1; step();
        rdchk("R7 cal started", MON_BASE, 8'h01);
        @(negedge clk); cal_busy = 0; step();
        rdchk("R7 cal ended", MON_BASE, 8'h03);
        @(negedge clk); out_lock = 1; step();
        rdchk("R8 out lock rise", MON_BASE, 8'h07);
        @(negedge clk); out_lock = 0; step();
        rdchk("R8 out lock fall", MON_BASE, 8'h0F);
        @(negedge clk); sys_lock = 1; step();
        rdchk("R8 sys lock rise", MON_BASE, 8'h1F);
        @(negedge clk); sys_lock = 0; step();
        rdchk("R8 sys lock fall", MON_BASE, 8'h3F);
        wr(CTRL_ADDR, 8'h01);
        rdchk("R5 clear all group 0", MON_BASE, 8'h00);
    endtask

    task automatic t_loop_map;
        @(negedge clk); phase_lock = 1; step();
        rdchk("R9 phase rise", MON_BASE + 5'd2, 8'h01);
        @(negedge clk); phase_lock = 0; step();
        rdchk("R9 phase fall", MON_BASE + 5'd2, 8'h03);
        @(negedge clk); freq_lock = 1; step();
        rdchk("R9 freq rise", MON_BASE + 5'd2, 8'h07);
        @(negedge clk); freq_lock = 0; step();
        rdchk("R9 freq fall", MON_BASE + 5'd2, 8'h0F);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); loop_evt = 4'(1 << i);
            @(negedge clk); loop_evt = '0;
            rdchk("R9 loop pulse", MON_BASE + 5'd2, 8'(8'hFF >> (3 - i)));
        end
    endtask

    task automatic t_lim_ref;
        @(negedge clk); slew_lim = 1; step();
        rdchk("R9 slew rise", MON_BASE + 5'd3, 8'h01);
        @(negedge clk); slew_lim = 0; step();
        rdchk("R9 slew fall", MON_BASE + 5'd3, 8'h03);
        @(negedge clk); freq_clamp = 1; step();
        @(negedge clk); freq_clamp = 0; step();
        rdchk("R9 clamp pair", MON_BASE + 5'd3, 8'h0F);
        @(negedge clk); hist_upd = 1; @(negedge clk); hist_upd = 0;
        rdchk("R9 history pulse", MON_BASE + 5'd3, 8'h1F);
        @(negedge clk); ref_fault[0] = 1; step();
        rdchk("R9 ref0 fault", MON_BASE + 5'd4, 8'h01);
        @(negedge clk); ref_fault[0] = 0; step();
        @(negedge clk); ref_valid[0] = 1; @(negedge clk); ref_valid[0] = 0;
        rdchk("R9 ref0 cleared and valid", MON_BASE + 5'd4, 8'h07);
        @(negedge clk); ref_fault[1] = 1; step();
        rdchk("R9 ref1 fault", MON_BASE + 5'd4, 8'h17);
        @(negedge clk); ref_fault[1] = 0; step();
        @(negedge clk); ref_valid[1] = 1; @(negedge clk); ref_valid[1] = 0;
        rdchk("R9 ref1 cleared and valid", MON_BASE + 5'd4, 8'h77);
    endtask

    task automatic t_sticky;
        repeat (10) step();
        rdchk("R3 limiter flags held", MON_BASE + 5'd3, 8'h1F);
        rdchk("R3 reference flags held", MON_BASE + 5'd4, 8'h77);
        irqchk("R11 irq held", 1'b1);
    endtask

    task automatic t_w1c;
        wr(CLR_BASE + 5'd2, 8'h0F);
        rdchk("R4 partial clear", MON_BASE + 5'd2, 8'hF0);
        rdchk("R4 other group untouched", MON_BASE + 5'd3, 8'h1F);
        rdchk("R12 clear reg reads 0", CLR_BASE + 5'd2, 8'h00);
        rdchk("R12 control reads 0", CTRL_ADDR, 8'h00);
        wr(MON_BASE + 5'd2, 8'h00);
        rdchk("R12 monitor write ignored", MON_BASE + 5'd2, 8'hF0);
    endtask

    task automatic t_clear_all;
        wr(CTRL_ADDR, 8'h01);
        for (int g = 0; g < GRP_N; g++) rdchk("R5 clear all", MON_BASE + 5'(g), 8'h00);
        irqchk("R11 irq low after clear all", 1'b0);
    endtask

    task automatic t_event_wins;
        @(negedge clk);
        addr = CLR_BASE + 5'd1; wr_data = 8'h04; wr_en = 1; misc_evt = 5'h04;
        @(negedge clk); wr_en = 0; misc_evt = '0;
        rdchk("R6 event beats clear", MON_BASE + 5'd1, 8'h04);
        @(negedge clk);
        addr = CTRL_ADDR; wr_data = 8'h01; wr_en = 1; misc_evt = 5'h01;
        @(negedge clk); wr_en = 0; misc_evt = '0;
        rdchk("R6 event beats clear all", MON_BASE + 5'd1, 8'h01);
        wr(CTRL_ADDR, 8'h01);
    endtask

    task automatic t_mask_keep;
        pulse_misc(5'h08);
        rdchk("R1 flag set", MON_BASE + 5'd1, 8'h08);
        wr(MASK_BASE + 5'd1, 8'hFF);
        rdchk("R2 mask write keeps flag", MON_BASE + 5'd1, 8'h08);
        pulse_misc(5'h02);
        rdchk("R2 newly masked bit blocked", MON_BASE + 5'd1, 8'h08);
        irqchk("R11 irq still high", 1'b1);
        wr(CLR_BASE + 5'd1, 8'h08);
        irqchk("R11 irq falls with last flag", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masked();
        t_unmask();
        t_misc_map();
        t_pll_map();
        t_loop_map();
        t_lim_ref();
        t_sticky();
        t_w1c();
        t_clear_all();
        t_event_wins();
        t_mask_keep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule